// File: doc/BRIEF.md
# MDIO Management Command Controller

This block is a management-bus master for Ethernet PHYs that sits behind three 16-bit host registers. Software loads a write-data register when it needs one, then writes a command word. The command word holds the PHY address, the register index and one of two start bits. The start bit launches a single clause-22 read or write frame on the serial management pins. That bit reads back as 1 until the frame has ended, and then clears by itself. Software therefore polls the command register, and after a read it fetches the result from a separate read-data register.

The serial clock is the system clock divided by an even parameter `CLK_DIV`. The default of 40 gives 2.5 MHz from a 100 MHz system clock. The data pin is driven through a separate output and output-enable, so a pad or an external open-drain stage can be attached. The controller samples data returned by the PHY on the rising edge of the serial clock. A full transfer takes a fixed number of system cycles, so a host that polls a bounded number of times knows how long to wait.

Top module: `mdio_cmd_ctrl`

## Requirements
- R1: After reset `mdc` is low, `mdio_oe` is low, and the command, read-data and write-data registers all read as 0.
- R2: Register select 0 is the command word, 1 is the read-data register and 2 is the write-data register. Select 3 reads as 0 and ignores writes. In the command word, bit 13 starts a read, bit 14 starts a write, bits 12:8 carry the PHY address and bits 4:0 carry the register index. Bits 15 and 7:5 read as 0, and the address fields read back as last accepted.
- R3: The start bit of the launched operation reads 1 from the cycle after the command is accepted. It clears exactly 64*`CLK_DIV` system cycles after the accepting edge.
- R4: Each frame is sent most significant bit first in this order: 32 ones, then 01, then the opcode (10 for a read, 01 for a write), then the 5-bit PHY address, then the 5-bit register index, then the turnaround, then 16 data bits. A write uses 10 as its turnaround.
- R5: A write frame carries the write-data register value held when the command was accepted. Rewriting that register during the frame changes the readback but not the frame.
- R6: During a read, `mdio_oe` is high for the first 46 bits and low for the turnaround and data bits. The 16 bits sampled at the rising `mdc` edges of the data field appear in the read-data register once the start bit clears. A write leaves the read-data register unchanged.
- R7: `mdc` has a period of `CLK_DIV` system cycles with equal high and low halves, and stays low while no transfer runs.
- R8: A command write accepted while a transfer is busy is ignored. The running frame, its fields, its start bit and the idle state that follows are all unchanged.
- R9: A command with both start bits set launches a read. A command with neither start bit set only stores the address fields and starts no frame.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select (0 command, 1 read data, 2 write data) |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Combinational readback of the selected register |
| mdc | output | 1 | Management serial clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input |

## Verification
The bench builds the block with `CLK_DIV` = 4, so a frame costs 256 system cycles. This keeps a dozen frames short while still using the counter-based divider rather than the toggle-every-cycle variant. At that setting the exact completion cycle is cheap to observe: one poll per cycle gives a count that must equal 64*`CLK_DIV`. The bench also runs a model of the PHY on the serial pins. It records every driven bit together with the enable, and it returns read data on falling `mdc` edges. This exposes the turnaround release and the ordering of the sampled data.

// File: rtl/mdio_ctrl_pkg.sv
package mdio_ctrl_pkg;

   localparam int DATA_W = 16;
   localparam int ADDR_W = 5;

   // register select codes
   localparam logic [1:0] SEL_CMD   = 2'd0;
   localparam logic [1:0] SEL_RDATA = 2'd1;
   localparam logic [1:0] SEL_WDATA = 2'd2;

   // command word layout
   localparam int CMD_RD_BIT  = 13;
   localparam int CMD_WR_BIT  = 14;
   localparam int CMD_PHY_LSB = 8;
   localparam int CMD_REG_LSB = 0;

   typedef struct packed {
      logic              is_read;
      logic [ADDR_W-1:0] phy;
      logic [ADDR_W-1:0] regad;
      logic [DATA_W-1:0] data;
   } mdio_req_t;

endpackage

// File: rtl/mdio_ctrl_clkgen.sv
module mdio_ctrl_clkgen #(
   parameter int CLK_DIV = 40
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic mdc,
   output logic rise_stb,
   output logic fall_stb
);
   localparam int HALF = CLK_DIV / 2;

   generate
      if (HALF == 1) begin : g_toggle
         logic mdc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      mdc_q <= 1'b0;
            else if (!run)   mdc_q <= 1'b0;
            else             mdc_q <= ~mdc_q;
         end
         assign mdc      = mdc_q;
         assign rise_stb = run && !mdc_q;
         assign fall_stb = run && mdc_q;
      end else begin : g_count
         localparam int CNT_W = $clog2(HALF);
         localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(HALF - 1);
         logic [CNT_W-1:0] cnt_q;
         logic             mdc_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               cnt_q <= '0;
               mdc_q <= 1'b0;
            end else if (!run) begin
               cnt_q <= '0;
               mdc_q <= 1'b0;
            end else if (cnt_q == CNT_LAST) begin
               cnt_q <= '0;
               mdc_q <= ~mdc_q;
            end else begin
               cnt_q <= cnt_q + 1'b1;
            end
         end
         assign mdc      = mdc_q;
         assign rise_stb = run && (cnt_q == CNT_LAST) && !mdc_q;
         assign fall_stb = run && (cnt_q == CNT_LAST) && mdc_q;
      end
   endgenerate

   // R7: serial clock parks low whenever no frame runs
   p_mdc_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !run |-> !mdc);

endmodule

// File: rtl/mdio_ctrl_frame.sv
module mdio_ctrl_frame
   import mdio_ctrl_pkg::*;
#(
   parameter int PREAMBLE_BITS = 32,
   parameter int CLK_DIV       = 40
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              launch,
   input  mdio_req_t         launch_req,
   input  logic              rise_stb,
   input  logic              fall_stb,
   input  logic              mdio_i,
   output logic              run,
   output logic              done,
   output logic [DATA_W-1:0] rd_word,
   output logic              mdio_o,
   output logic              mdio_oe
);
   localparam int FRAME_BITS = PREAMBLE_BITS + 4 + 2*ADDR_W + 2 + DATA_W;
   localparam int IDX_W      = $clog2(FRAME_BITS);
   localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(FRAME_BITS - 1);
   localparam logic [IDX_W-1:0] IDX_TA   = IDX_W'(DATA_W + 1);
   localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(DATA_W);
   localparam int XFER_CYC = FRAME_BITS * CLK_DIV;
   localparam int CYC_W    = $clog2(XFER_CYC + 1);

   logic                  run_q;
   mdio_req_t             req_q;
   logic [IDX_W-1:0]      left_q;
   logic [DATA_W-1:0]     shreg_q;
   logic [FRAME_BITS-1:0] frame_w;

   always_comb begin
      frame_w = {{PREAMBLE_BITS{1'b1}}, 2'b01,
                 (req_q.is_read ? 2'b10 : 2'b01),
                 req_q.phy, req_q.regad, 2'b10, req_q.data};
   end

   assign run     = run_q;
   assign done    = run_q && fall_stb && (left_q == '0);
   assign rd_word = shreg_q;
   assign mdio_o  = run_q ? frame_w[left_q] : 1'b1;
   assign mdio_oe = run_q && (!req_q.is_read || (left_q > IDX_TA));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q   <= 1'b0;
         req_q   <= '0;
         left_q  <= '0;
         shreg_q <= '0;
      end else if (launch) begin
         run_q  <= 1'b1;
         req_q  <= launch_req;
         left_q <= IDX_TOP;
      end else if (run_q) begin
         if (rise_stb && req_q.is_read && (left_q < IDX_DATA))
            shreg_q <= {shreg_q[DATA_W-2:0], mdio_i};
         if (fall_stb) begin
            if (left_q == '0) run_q  <= 1'b0;
            else              left_q <= left_q - 1'b1;
         end
      end
   end

   // cycle counter used only to check the transfer length
   logic [CYC_W-1:0] cyc_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cyc_q <= '0;
      else if (launch)  cyc_q <= '0;
      else if (run_q)   cyc_q <= cyc_q + 1'b1;
   end

   // R3: frame ends a fixed number of cycles after launch
   p_done_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (cyc_q == CYC_W'(XFER_CYC - 1)));

endmodule

// File: rtl/mdio_ctrl_regs.sv
module mdio_ctrl_regs
   import mdio_ctrl_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              xfer_done,
   input  logic [DATA_W-1:0] xfer_rdata,
   output logic              launch,
   output mdio_req_t         launch_req,
   output logic [DATA_W-1:0] rdata,
   output logic              busy
);
   logic              rd_busy_q, wr_busy_q;
   logic [ADDR_W-1:0] phy_q, reg_q;
   logic [DATA_W-1:0] wdat_q, rres_q;
   logic              cmd_acc, want_rd, want_wr;

   assign busy    = rd_busy_q | wr_busy_q;
   assign want_rd = wdata[CMD_RD_BIT];
   assign want_wr = wdata[CMD_WR_BIT];
   assign cmd_acc = wr_en && (sel == SEL_CMD) && !busy;
   assign launch  = cmd_acc && (want_rd || want_wr);

   always_comb begin
      launch_req.is_read = want_rd;
      launch_req.phy     = wdata[CMD_PHY_LSB +: ADDR_W];
      launch_req.regad   = wdata[CMD_REG_LSB +: ADDR_W];
      launch_req.data    = wdat_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rd_busy_q <= 1'b0;
         wr_busy_q <= 1'b0;
         phy_q     <= '0;
         reg_q     <= '0;
         rres_q    <= '0;
      end else if (cmd_acc) begin
         phy_q     <= wdata[CMD_PHY_LSB +: ADDR_W];
         reg_q     <= wdata[CMD_REG_LSB +: ADDR_W];
         rd_busy_q <= want_rd;
         wr_busy_q <= want_wr && !want_rd;
      end else if (xfer_done) begin
         if (rd_busy_q) rres_q <= xfer_rdata;
         rd_busy_q <= 1'b0;
         wr_busy_q <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              wdat_q <= '0;
      else if (wr_en && (sel == SEL_WDATA))    wdat_q <= wdata;
   end

   always_comb begin
      rdata = '0;
      case (sel)
         SEL_CMD: begin
            rdata[CMD_RD_BIT]                = rd_busy_q;
            rdata[CMD_WR_BIT]                = wr_busy_q;
            rdata[CMD_PHY_LSB +: ADDR_W]     = phy_q;
            rdata[CMD_REG_LSB +: ADDR_W]     = reg_q;
         end
         SEL_RDATA: rdata = rres_q;
         SEL_WDATA: rdata = wdat_q;
         default:   rdata = '0;
      endcase
   end

   // R2: at most one start bit is ever set
   p_one_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_busy_q, wr_busy_q}));

   // R8: a command during a busy transfer leaves the fields alone
   p_fields_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && wr_en && (sel == SEL_CMD)) |=> ($stable(phy_q) && $stable(reg_q)));

   // R6: the read result only moves when a read finishes
   p_rdata_update_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(rres_q) |-> $fell(rd_busy_q));

endmodule

// File: rtl/mdio_cmd_ctrl.sv
module mdio_cmd_ctrl
   import mdio_ctrl_pkg::*;
#(
   parameter int CLK_DIV       = 40,
   parameter int PREAMBLE_BITS = 32
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        reg_wr,
   input  logic [1:0]  reg_sel,
   input  logic [15:0] reg_wdata,
   output logic [15:0] reg_rdata,
   output logic        mdc,
   output logic        mdio_o,
   output logic        mdio_oe,
   input  logic        mdio_i
);
   generate
      if (CLK_DIV < 2 || (CLK_DIV % 2) != 0) begin : g_bad_div
         $error("CLK_DIV must be even and at least 2");
      end
      if (PREAMBLE_BITS < 1) begin : g_bad_pre
         $error("PREAMBLE_BITS must be at least 1");
      end
      if (DATA_W != 16) begin : g_bad_width
         $error("register width must be 16");
      end
   endgenerate

   logic              launch, busy, run, done, rise_stb, fall_stb;
   mdio_req_t         launch_req;
   logic [DATA_W-1:0] rd_word;

   mdio_ctrl_regs u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (reg_wr),
      .sel        (reg_sel),
      .wdata      (reg_wdata),
      .xfer_done  (done),
      .xfer_rdata (rd_word),
      .launch     (launch),
      .launch_req (launch_req),
      .rdata      (reg_rdata),
      .busy       (busy)
   );

   mdio_ctrl_clkgen #(.CLK_DIV(CLK_DIV)) u_clkgen (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (run),
      .mdc      (mdc),
      .rise_stb (rise_stb),
      .fall_stb (fall_stb)
   );

   mdio_ctrl_frame #(.PREAMBLE_BITS(PREAMBLE_BITS), .CLK_DIV(CLK_DIV)) u_frame (
      .clk        (clk),
      .rst_n      (rst_n),
      .launch     (launch),
      .launch_req (launch_req),
      .rise_stb   (rise_stb),
      .fall_stb   (fall_stb),
      .mdio_i     (mdio_i),
      .run        (run),
      .done       (done),
      .rd_word    (rd_word),
      .mdio_o     (mdio_o),
      .mdio_oe    (mdio_oe)
   );

   // R3: host-visible start bits track the running frame
   p_flag_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
      busy == run);

endmodule

// File: tb/tb_mdio_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_mdio_cmd_ctrl;
   localparam int DIV   = 4;
   localparam int XFER  = 64 * DIV;

   // {is_write, phy, reg, write data, PHY read value}
   localparam logic [42:0] VEC [0:7] = '{
      {1'b0, 5'd1,  5'd1,  16'h0000, 16'h796D},
      {1'b1, 5'd1,  5'd4,  16'h01E1, 16'h0000},
      {1'b1, 5'd2,  5'd0,  16'h3100, 16'h0000},
      {1'b0, 5'd31, 5'd31, 16'h0000, 16'hFFFF},
      {1'b0, 5'd0,  5'd0,  16'h0000, 16'h0000},
      {1'b1, 5'd29, 5'd31, 16'h175C, 16'h0000},
      {1'b0, 5'd30, 5'd17, 16'h0000, 16'hA5C3},
      {1'b1, 5'd0,  5'd19, 16'h8001, 16'h0000}
   };

   logic        clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0, mdio_i = 1'b1;
   logic [1:0]  reg_sel = 2'd0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        mdc, mdio_o, mdio_oe;

   int checks = 0, errors = 0;

   always #5 clk = ~clk;

   mdio_cmd_ctrl #(.CLK_DIV(DIV)) dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc),
      .mdio_o(mdio_o), .mdio_oe(mdio_oe), .mdio_i(mdio_i)
   );

   // PHY model
   logic [63:0] cap_frame = '0, cap_oe = '0;
   int          nbits = 0, base = 0;
   logic [15:0] phy_val = '0;
   time         t_rise = 0, t_prev = 0;

   always @(posedge mdc) begin
      cap_frame = {cap_frame[62:0], mdio_o};
      cap_oe    = {cap_oe[62:0], mdio_oe};
      nbits     = nbits + 1;
      t_prev    = t_rise;
      t_rise    = $time;
   end

   always @(negedge mdc) begin
      int k;
      k = nbits - base;
      if (k >= 48 && k < 64) mdio_i = phy_val[63 - k];
      else                   mdio_i = 1'b1;
   end

   task automatic check(string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic reg_write(logic [1:0] s, logic [15:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic reg_read(logic [1:0] s, output logic [15:0] d);
      reg_sel = s;
      #1;
      d = reg_rdata;
   endtask

   task automatic poll(output int n);
      logic [15:0] v;
      n = 0;
      reg_read(2'd0, v);
      while ((v[14] || v[13]) && n < 5000) begin
         n++;
         @(negedge clk);
         reg_read(2'd0, v);
      end
   endtask

   function automatic logic [63:0] exp_frame(logic wr, logic [4:0] p, logic [4:0] r, logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, 2'b10, d};
   endfunction

   function automatic logic [15:0] cmd_word(logic wr, logic rd, logic [4:0] p, logic [4:0] r);
      return {1'b0, wr, rd, p, 3'b000, r};
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [15:0] v, last_rd;
      logic [63:0] ef;
      int n, snap;

      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "mdc", {63'd0, mdc}, 64'd0);
      check("R1", "mdio_oe", {63'd0, mdio_oe}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      reg_read(2'd0, v); check("R1", "cmd reg", {48'd0, v}, 64'd0);
      reg_read(2'd1, v); check("R1", "read-data reg", {48'd0, v}, 64'd0);
      reg_read(2'd2, v); check("R1", "write-data reg", {48'd0, v}, 64'd0);
      last_rd = '0;

      // table walk
      for (int i = 0; i < 8; i++) begin
         logic [42:0] tv;
         logic        wr;
         logic [4:0]  p, r;
         logic [15:0] wd, pv;
         tv = VEC[i];
         {wr, p, r, wd, pv} = tv;
         base = nbits; phy_val = pv;
         if (wr) reg_write(2'd2, wd);
         reg_write(2'd0, cmd_word(wr, !wr, p, r));
         poll(n);
         check("R3", "busy cycles", 64'(n), 64'(XFER));
         ef = exp_frame(wr, p, r, wd);
         if (wr) begin
            check("R4", "write frame", cap_frame, ef);
            check("R6", "write oe", cap_oe, {64{1'b1}});
            check("R5", "write data bits", {48'd0, cap_frame[15:0]}, {48'd0, wd});
            reg_read(2'd1, v);
            check("R6", "rdata kept on write", {48'd0, v}, {48'd0, last_rd});
         end else begin
            check("R4", "read frame head", {18'd0, cap_frame[63:18]}, {18'd0, ef[63:18]});
            check("R6", "read oe", cap_oe, {{46{1'b1}}, 18'd0});
            reg_read(2'd1, v);
            check("R6", "read result", {48'd0, v}, {48'd0, pv});
            last_rd = pv;
         end
         reg_read(2'd0, v);
         check("R2", "cmd readback", {48'd0, v}, {48'd0, cmd_word(1'b0, 1'b0, p, r)});
         if (i == 0) begin
            check("R7", "mdc period", 64'(t_rise - t_prev), 64'(DIV * 10));
            check("R7", "mdc idle low", {63'd0, mdc}, 64'd0);
         end
      end

      // R7: high half
      begin
         time th;
         base = nbits;
         reg_write(2'd0, cmd_word(1'b0, 1'b1, 5'd4, 5'd4));
         @(posedge mdc); th = $time;
         @(negedge mdc);
         check("R7", "mdc high time", 64'($time - th), 64'(DIV * 5));
         poll(n);
      end

      // R8: command while busy is ignored
      base = nbits; phy_val = 16'h5A5A;
      reg_write(2'd0, cmd_word(1'b0, 1'b1, 5'd3, 5'd2));
      repeat (40) @(negedge clk);
      reg_write(2'd0, cmd_word(1'b1, 1'b0, 5'd9, 5'd9));
      reg_read(2'd0, v);
      check("R8", "cmd during busy", {48'd0, v}, {48'd0, cmd_word(1'b0, 1'b1, 5'd3, 5'd2)});
      poll(n);
      ef = exp_frame(1'b0, 5'd3, 5'd2, 16'h0000);
      check("R8", "frame unchanged", {18'd0, cap_frame[63:18]}, {18'd0, ef[63:18]});
      reg_read(2'd1, v);
      check("R8", "read result", {48'd0, v}, {48'd0, 16'h5A5A});
      snap = nbits;
      repeat (30) @(negedge clk);
      reg_read(2'd0, v);
      check("R8", "no second frame", 64'(nbits - snap), 64'd0);
      check("R8", "idle after", {48'd0, v}, {48'd0, cmd_word(1'b0, 1'b0, 5'd3, 5'd2)});

      // R9: both start bits set -> read
      base = nbits; phy_val = 16'h0F0F;
      reg_write(2'd0, cmd_word(1'b1, 1'b1, 5'd4, 5'd7));
      reg_read(2'd0, v);
      check("R9", "both bits busy", {62'd0, v[14:13]}, 64'd1);
      poll(n);
      ef = exp_frame(1'b0, 5'd4, 5'd7, 16'h0000);
      check("R9", "both bits frame", {18'd0, cap_frame[63:18]}, {18'd0, ef[63:18]});
      reg_read(2'd1, v);
      check("R9", "both bits result", {48'd0, v}, {48'd0, 16'h0F0F});

      // R9: neither start bit -> fields only
      snap = nbits;
      reg_write(2'd0, cmd_word(1'b0, 1'b0, 5'd21, 5'd6));
      repeat (40) @(negedge clk);
      reg_read(2'd0, v);
      check("R9", "fields only", {48'd0, v}, {48'd0, cmd_word(1'b0, 1'b0, 5'd21, 5'd6)});
      check("R9", "no frame", 64'(nbits - snap), 64'd0);
      check("R9", "mdc low", {63'd0, mdc}, 64'd0);

      // R5: write-data rewritten mid-frame
      base = nbits;
      reg_write(2'd2, 16'h1234);
      reg_write(2'd0, cmd_word(1'b1, 1'b0, 5'd5, 5'd3));
      repeat (20) @(negedge clk);
      reg_write(2'd2, 16'hBEEF);
      poll(n);
      check("R5", "frame keeps old data", cap_frame, exp_frame(1'b1, 5'd5, 5'd3, 16'h1234));
      reg_read(2'd2, v);
      check("R5", "wdata readback", {48'd0, v}, {48'd0, 16'hBEEF});

      // R2: select 3 reads zero and ignores writes
      reg_write(2'd3, 16'hFFFF);
      reg_read(2'd3, v);
      check("R2", "sel 3 reads 0", {48'd0, v}, 64'd0);
      reg_read(2'd0, v);
      check("R2", "sel 3 write ignored", {48'd0, v}, {48'd0, cmd_word(1'b0, 1'b0, 5'd5, 5'd3)});

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule